// File: doc/BRIEF.md
# Subpixel Horizontal Phase Shifter

This block delays a luma stream and a multiplexed chroma stream by a programmable fraction of a pixel. A sync measurement upstream supplies a skew code once per line; the block captures that code on the line's first sample and uses it as a constant offset until the next line begins. Each output sample is a linear blend of two input samples. Luma blends neighbouring samples in steps of 1/32 of a pixel. Chroma blends samples of the same colour component, two positions apart because Cb and Cr alternate, in steps of 1/8.

The stream is qualified by a valid strobe, and a line-start marker comes with the first sample of each line. A small line-position state machine decides which taps each sample uses. It has three states. WAIT means no line has started since reset. HEAD means only the first sample of the current line has been taken. BODY means two or more samples have been taken. Its transitions are OPEN (WAIT to HEAD on a line start), DROP (WAIT stays WAIT on a sample without a line start), ADVANCE (HEAD to BODY on a sample without a line start), RESTART (HEAD or BODY to HEAD on a line start) and CONTINUE (BODY stays BODY). Outputs are registered and appear two cycles after the accepted input.

Top module: `pshift_top`

## Requirements
- R1: The luma output is floor(((32-p)·a + p·b + 16) / 32). Here b is the current luma sample, a is the previous luma sample of the same line, and p is the 5-bit latched skew code, giving a shift of 0 to 31/32 pixel.
- R2: The chroma output is floor(((8-q)·a + q·b + 4) / 8). Here q is bits [4:2] of the latched skew code, b is the current chroma sample and a is the chroma sample two positions earlier in the same line.
- R3: The skew code is captured only on a sample that has both valid and line start set. Changes on the skew input during the rest of the line have no effect.
- R4: On a line-start sample, the luma and chroma outputs equal that sample's inputs. No data from the previous line is used.
- R5: On the second sample of a line, the chroma output equals the current chroma input, and the luma output blends the first and second samples.
- R6: After reset, valid samples that arrive before the first line start are discarded and produce no valid output.
- R7: An accepted sample produces out_valid high exactly two clock cycles later. A cycle with no accepted sample produces out_valid low two cycles later.
- R8: While out_valid is low, out_luma and out_chroma keep their previous values.
- R9: During and directly after reset, out_valid, out_luma and out_chroma are 0.
- R10: Each luma output lies between its two taps, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sol | input | 1 | Marks the first sample of a line (meaningful with in_valid) |
| skew_code | input | 5 | Fractional skew in 1/32 pixel, captured at line start |
| in_luma | input | 8 | Luma sample |
| in_chroma | input | 8 | Multiplexed Cb/Cr sample |
| out_valid | output | 1 | Output sample strobe |
| out_luma | output | 8 | Phase-shifted luma |
| out_chroma | output | 8 | Phase-shifted chroma |

## Verification
The bench targets these cases:
- A skew code that changes in mid-line. A design that follows it live would shift the later part of the line by a different phase.
- The first and second samples of a line. A design that fails to seed its history would blend in the last pixels of the previous line, or mix Cb into Cr.
- Phase codes 1 and 31. Here a rounding error or weights in the wrong order would be off by one or more.
- The choice of chroma phase bits. A design that takes the low bits instead of the high bits gives a visibly wrong blend.
- Samples before the first line start after reset, and idle gaps. A design that gets these wrong would emit spurious valid outputs or let the held data drift.

// File: rtl/pshift_pkg.sv
package pshift_pkg;

    // Position of the stream within the current line
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,   // no line start seen since reset
        ST_HEAD = 2'd1,   // first sample of the line taken
        ST_BODY = 2'd2    // two or more samples of the line taken
    } line_st_e;

    // Which earlier samples feed the interpolators for the incoming sample
    typedef enum logic [1:0] {
        SEL_SEED = 2'd0,  // line start: both taps are the current sample
        SEL_HEAD = 2'd1,  // second sample: luma uses previous, chroma seeds
        SEL_BODY = 2'd2   // steady state: luma n-1, chroma n-2
    } tap_sel_e;

endpackage

// File: rtl/pshift_ctrl.sv
module pshift_ctrl
    import pshift_pkg::*;
#(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sol,
    input  logic [PW-1:0] skew_code,
    output logic          accept,
    output tap_sel_e      tap_sel,
    output logic [PW-1:0] phase
);

    line_st_e      state_q;
    line_st_e      state_d;
    logic [PW-1:0] skew_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: OPEN, DROP, ADVANCE, RESTART, CONTINUE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (in_valid && in_sol) state_d = ST_HEAD;          // OPEN
            end
            ST_HEAD: begin
                if (in_valid) state_d = in_sol ? ST_HEAD : ST_BODY; // RESTART / ADVANCE
            end
            ST_BODY: begin
                if (in_valid && in_sol) state_d = ST_HEAD;          // RESTART
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // Outputs decoded from state and the incoming sample
    always_comb begin
        accept  = in_valid && (in_sol || (state_q != ST_WAIT));
        phase   = in_sol ? skew_code : skew_q;
        tap_sel = SEL_BODY;
        unique case (state_q)
            ST_WAIT: tap_sel = SEL_SEED;
            ST_HEAD: tap_sel = in_sol ? SEL_SEED : SEL_BODY;
            ST_BODY: tap_sel = in_sol ? SEL_SEED : SEL_BODY;
            default: tap_sel = SEL_SEED;
        endcase
        // A sample right after the line start has only one chroma of its kind
        if ((state_q == ST_HEAD) && !in_sol) tap_sel = SEL_HEAD;
    end

    // Skew offset held for the whole line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skew_q <= '0;
        end else if (in_valid && in_sol) begin
            skew_q <= skew_code;
        end
    end

endmodule

// File: rtl/pshift_lerp.sv
module pshift_lerp #(
    parameter int DW = 8,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] tap_a,
    input  logic [DW-1:0] tap_b,
    input  logic [PW-1:0] frac,
    output logic [DW-1:0] y
);

    localparam int SW   = DW + PW + 1;
    localparam int UNIT = 1 << PW;
    localparam int HALF = 1 << (PW - 1);

    logic [SW-1:0] w_a;
    logic [SW-1:0] w_b;
    logic [SW-1:0] acc;

    // Weighted sum with half-step bias for round-to-nearest
    always_comb begin
        w_b = SW'(frac);
        w_a = SW'(UNIT) - w_b;
        acc = w_a * SW'(tap_a) + w_b * SW'(tap_b) + SW'(HALF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y <= '0;
        end else if (en) begin
            y <= acc[PW +: DW];
        end
    end

endmodule

// File: rtl/pshift_top.sv
module pshift_top
    import pshift_pkg::*;
#(
    parameter int DW  = 8,
    parameter int LPW = 5,
    parameter int CPW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           in_sol,
    input  logic [LPW-1:0] skew_code,
    input  logic [DW-1:0]  in_luma,
    input  logic [DW-1:0]  in_chroma,
    output logic           out_valid,
    output logic [DW-1:0]  out_luma,
    output logic [DW-1:0]  out_chroma
);

    localparam int CLSB = LPW - CPW;

    logic           accept;
    tap_sel_e       tap_sel;
    logic [LPW-1:0] phase;

    logic [DW-1:0]  y_prev;
    logic [DW-1:0]  c_h1;
    logic [DW-1:0]  c_h2;
    logic [DW-1:0]  y_a;
    logic [DW-1:0]  c_a;

    logic           s1_v;
    logic [DW-1:0]  s1_ya;
    logic [DW-1:0]  s1_yb;
    logic [DW-1:0]  s1_ca;
    logic [DW-1:0]  s1_cb;
    logic [LPW-1:0] s1_ph;

    pshift_ctrl #(.PW(LPW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sol    (in_sol),
        .skew_code (skew_code),
        .accept    (accept),
        .tap_sel   (tap_sel),
        .phase     (phase)
    );

    // Sample history inside the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_prev <= '0;
            c_h1   <= '0;
            c_h2   <= '0;
        end else if (accept) begin
            y_prev <= in_luma;
            c_h1   <= in_chroma;
            c_h2   <= (tap_sel == SEL_SEED) ? in_chroma : c_h1;
        end
    end

    // Earlier tap per path
    always_comb begin
        y_a = y_prev;
        c_a = in_chroma;
        unique case (tap_sel)
            SEL_SEED: begin y_a = in_luma; c_a = in_chroma; end
            SEL_HEAD: begin y_a = y_prev;  c_a = in_chroma; end
            SEL_BODY: begin y_a = y_prev;  c_a = c_h2;      end
            default:  begin y_a = in_luma; c_a = in_chroma; end
        endcase
    end

    // Stage 1: tap registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v  <= 1'b0;
            s1_ya <= '0;
            s1_yb <= '0;
            s1_ca <= '0;
            s1_cb <= '0;
            s1_ph <= '0;
        end else begin
            s1_v <= accept;
            if (accept) begin
                s1_ya <= y_a;
                s1_yb <= in_luma;
                s1_ca <= c_a;
                s1_cb <= in_chroma;
                s1_ph <= phase;
            end
        end
    end

    // Stage 2: interpolators, one per path resolution
    pshift_lerp #(.DW(DW), .PW(LPW)) u_lerp_y (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (s1_v),
        .tap_a (s1_ya),
        .tap_b (s1_yb),
        .frac  (s1_ph),
        .y     (out_luma)
    );

    generate
        if (CPW == LPW) begin : g_c_full
            pshift_lerp #(.DW(DW), .PW(CPW)) u_lerp_c (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (s1_v),
                .tap_a (s1_ca),
                .tap_b (s1_cb),
                .frac  (s1_ph),
                .y     (out_chroma)
            );
        end else begin : g_c_coarse
            pshift_lerp #(.DW(DW), .PW(CPW)) u_lerp_c (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (s1_v),
                .tap_a (s1_ca),
                .tap_b (s1_cb),
                .frac  (s1_ph[CLSB +: CPW]),
                .y     (out_chroma)
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= s1_v;
        end
    end

endmodule

// File: rtl/pshift_chk.sv
module pshift_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_sol,
    input logic [DW-1:0] in_luma,
    input logic [DW-1:0] in_chroma,
    input logic          out_valid,
    input logic [DW-1:0] out_luma,
    input logic [DW-1:0] out_chroma,
    input logic          tap_v,
    input logic [DW-1:0] tap_lo,
    input logic [DW-1:0] tap_hi
);

    a_r4_seed_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol) |=> ##1 ((out_luma == $past(in_luma, 2)) &&
                                      (out_chroma == $past(in_chroma, 2))));

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol) |=> ##1 out_valid);

    a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_luma) && $stable(out_chroma)));

    a_r10_between_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_v && (tap_lo <= tap_hi)) |=>
            ((out_luma >= $past(tap_lo)) && (out_luma <= $past(tap_hi))));

    a_r10_between_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_v && (tap_lo > tap_hi)) |=>
            ((out_luma <= $past(tap_lo)) && (out_luma >= $past(tap_hi))));

endmodule

bind pshift_top pshift_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sol     (in_sol),
    .in_luma    (in_luma),
    .in_chroma  (in_chroma),
    .out_valid  (out_valid),
    .out_luma   (out_luma),
    .out_chroma (out_chroma),
    .tap_v      (s1_v),
    .tap_lo     (s1_ya),
    .tap_hi     (s1_yb)
);

// File: tb/sim_pshift_top.sv
`timescale 1ns/1ps
module sim_pshift_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sol = 1'b0;
    logic [4:0] skew_code = '0;
    logic [7:0] in_luma = '0;
    logic [7:0] in_chroma = '0;
    logic       out_valid;
    logic [7:0] out_luma;
    logic [7:0] out_chroma;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pshift_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sol     (in_sol),
        .skew_code  (skew_code),
        .in_luma    (in_luma),
        .in_chroma  (in_chroma),
        .out_valid  (out_valid),
        .out_luma   (out_luma),
        .out_chroma (out_chroma)
    );

    typedef struct packed {
        logic       v;
        logic       sol;
        logic [4:0] sk;
        logic [7:0] y;
        logic [7:0] c;
        logic       ev;
        logic [7:0] ey;
        logic [7:0] ec;
    } vec_t;

    localparam int NV = 16;
    // Expected outputs are hand-computed from the R1/R2 formulas
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 5'd9,  8'd50,  8'd60,  1'b0, 8'd0,   8'd0  },
        '{1'b1, 1'b1, 5'd8,  8'd100, 8'd200, 1'b1, 8'd100, 8'd200},
        '{1'b1, 1'b0, 5'd31, 8'd132, 8'd40,  1'b1, 8'd108, 8'd40 },
        '{1'b1, 1'b0, 5'd0,  8'd68,  8'd120, 1'b1, 8'd116, 8'd180},
        '{1'b0, 1'b0, 5'd0,  8'd7,   8'd7,   1'b0, 8'd116, 8'd180},
        '{1'b1, 1'b0, 5'd5,  8'd69,  8'd0,   1'b1, 8'd68,  8'd30 },
        '{1'b1, 1'b1, 5'd1,  8'd10,  8'd255, 1'b1, 8'd10,  8'd255},
        '{1'b1, 1'b0, 5'd0,  8'd41,  8'd1,   1'b1, 8'd11,  8'd1  },
        '{1'b1, 1'b0, 5'd0,  8'd255, 8'd3,   1'b1, 8'd48,  8'd255},
        '{1'b1, 1'b1, 5'd31, 8'd0,   8'd0,   1'b1, 8'd0,   8'd0  },
        '{1'b1, 1'b0, 5'd2,  8'd255, 8'd100, 1'b1, 8'd247, 8'd100},
        '{1'b1, 1'b0, 5'd2,  8'd0,   8'd9,   1'b1, 8'd8,   8'd8  },
        '{1'b1, 1'b0, 5'd2,  8'd1,   8'd200, 1'b1, 8'd1,   8'd188},
        '{1'b1, 1'b1, 5'd16, 8'd255, 8'd255, 1'b1, 8'd255, 8'd255},
        '{1'b1, 1'b0, 5'd0,  8'd254, 8'd0,   1'b1, 8'd255, 8'd0  },
        '{1'b0, 1'b0, 5'd0,  8'd1,   8'd1,   1'b0, 8'd255, 8'd0  }
    };

    function automatic string tag_of(int i);
        case (i)
            0:             return "R6";
            1, 6, 9, 13:   return "R4";
            2, 7, 10:      return "R5";
            3:             return "R3";
            4, 15:         return "R8";
            11:            return "R2";
            14:            return "R10";
            default:       return "R1";
        endcase
    endfunction

    task automatic check(string tag, logic ev, logic [7:0] ey, logic [7:0] ec);
        n_run++;
        if (out_valid !== ev || out_luma !== ey || out_chroma !== ec) begin
            n_fail++;
            $display("FAIL %s: got v=%0b y=%0d c=%0d, expected v=%0b y=%0d c=%0d",
                     tag, out_valid, out_luma, out_chroma, ev, ey, ec);
        end
    endtask

    // One sample, one idle cycle; returns at the cycle the result is visible
    task automatic send(logic sol, logic [4:0] sk, logic [7:0] y, logic [7:0] c);
        @(negedge clk);
        in_valid = 1'b1; in_sol = sol; skew_code = sk; in_luma = y; in_chroma = c;
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", 1'b0, 8'd0, 8'd0);           // R9 state under reset
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 1'b0, 8'd0, 8'd0);           // R9 just after release

        // Table walk: one sample per cycle, result checked two cycles later (R7)
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2)
                check({tag_of(i - 2), "/R7"}, TBL[i-2].ev, TBL[i-2].ey, TBL[i-2].ec);
            if (i < NV) begin
                in_valid  = TBL[i].v;
                in_sol    = TBL[i].sol;
                skew_code = TBL[i].sk;
                in_luma   = TBL[i].y;
                in_chroma = TBL[i].c;
            end else begin
                in_valid = 1'b0;
                in_sol   = 1'b0;
            end
        end

        // R8: long idle gap keeps the last result
        repeat (5) @(negedge clk);
        check("R8", 1'b0, 8'd255, 8'd0);

        // R2: chroma phase comes from skew bits [4:2]; code 3 gives q=0
        send(1'b1, 5'd3, 8'd0, 8'd0);
        check("R4", 1'b1, 8'd0, 8'd0);
        send(1'b0, 5'd0, 8'd32, 8'd80);
        check("R5", 1'b1, 8'd3, 8'd80);
        send(1'b0, 5'd0, 8'd0, 8'd160);
        check("R2", 1'b1, 8'd29, 8'd0);

        // R9/R6: reset mid-stream, then samples without a line start
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R9", 1'b0, 8'd0, 8'd0);
        send(1'b0, 5'd7, 8'd90, 8'd91);
        check("R6", 1'b0, 8'd0, 8'd0);
        send(1'b0, 5'd7, 8'd92, 8'd93);
        check("R6", 1'b0, 8'd0, 8'd0);
        // first line start after reset opens the line with pass-through (R4)
        send(1'b1, 5'd12, 8'd77, 8'd66);
        check("R4", 1'b1, 8'd77, 8'd66);
        // p=12: (20*77 + 12*13 + 16)/32 = 1712/32 -> 53
        send(1'b0, 5'd31, 8'd13, 8'd5);
        check("R1", 1'b1, 8'd53, 8'd5);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule